// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block is the column-address half of one SDRAM bank. On every rising clock edge it decodes the command pins. It tracks whether a row is open and how many edges have passed since that row was activated. When a read or write command arrives and enough cycles have passed since activation, it latches the start column and the burst mode. From the next cycle on, it issues one column address per clock.

Ordering is sequential or interleaved. Every address stays inside the window aligned to the burst length that holds the start column. A full-page burst wraps through the whole page and only ends when a stop request or another column command arrives. A column command that comes too early, or when no row is open, is refused and flagged for one cycle. A burst already in progress continues.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `valid_o` and `trcd_err_o` are low.
- R2: Commands are decoded from the pins sampled at the rising edge. ras_n=0, cas_n=1, we_n=1 is activate. ras_n=0, cas_n=1, we_n=0 is precharge. ras_n=1, cas_n=0 is a column command: we_n=1 means read and we_n=0 means write. `write_o` holds the inverse of we_n captured with the accepted command for the whole burst.
- R3: A column command is accepted only when a row is open and at least TRCD rising edges separate it from the activate edge (TRCD=3 by default). Otherwise it is refused: `trcd_err_o` is high for exactly the one cycle after that edge, and any burst in progress goes on unchanged.
- R4: After an accepted column command, `valid_o` is high in the very next cycle, and `col_o` carries the start column.
- R5: `burst_len_i` code 0, 1, 2 and 3 selects lengths 1, 2, 4 and 8, and such a burst ends by itself after exactly that many valid cycles. Code 7 selects full page. Codes 4 to 6 behave as length 1.
- R6: In sequential order, address n equals the start column with its low log2(L) bits replaced by (start + n) mod L, where L is the burst length.
- R7: In interleaved order (`interleave_i`=1), address n equals the start column with its low log2(L) bits XORed with n. With L=8 and start 2, the sequence is 2,3,0,1,6,7,4,5.
- R8: A full-page burst steps the column by one per cycle, wraps from PAGE-1 to 0 (PAGE = 2^COL_W = 256), and never ends by itself.
- R9: A full-page burst always runs in sequential order, whatever `interleave_i` is.
- R10: An accepted column command during a burst aborts that burst, and the new burst's start column appears in the next cycle.
- R11: `stop_i` high at an edge ends the current burst, so `valid_o` is low in the next cycle. An accepted column command at the same edge takes priority and starts its burst.
- R12: A precharge closes the row, so a later column command is refused as in R3 until a new activate and its delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; commands sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ras_n_i | input | 1 | Row strobe, active low |
| cas_n_i | input | 1 | Column strobe, active low |
| we_n_i | input | 1 | Write enable, active low |
| col_i | input | COL_W | Start column for a column command |
| burst_len_i | input | 3 | Burst length code (see R5) |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| stop_i | input | 1 | Ends the current burst |
| col_o | output | COL_W | Current burst column |
| valid_o | output | 1 | `col_o` is a live burst address |
| write_o | output | 1 | 1 = current burst is a write |
| trcd_err_o | output | 1 | One-cycle flag for a refused column command |

## Verification
Two pairs of events can land on the same edge, and both are provoked on purpose.

The first pair is a stop request and a new column command. The bench raises `stop_i` while it issues a new column command in the middle of an eight-beat burst. The scoreboard then expects the old burst to end after two beats and the new two-beat burst to run in full, with no gap.

The second pair is a refused command and a running burst. A precharge followed by a column command lands while a burst is still in progress. The bench expects `trcd_err_o` for exactly one cycle, and it expects every remaining beat of the burst to arrive unchanged.

// File: rtl/sdram_col_pkg.sv
package sdram_col_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_PRE,
    CMD_RD,
    CMD_WR
  } cmd_e;

  localparam logic [2:0] BL_1    = 3'd0;
  localparam logic [2:0] BL_2    = 3'd1;
  localparam logic [2:0] BL_4    = 3'd2;
  localparam logic [2:0] BL_8    = 3'd3;
  localparam logic [2:0] BL_PAGE = 3'd7;
endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_col_pkg::*;
(
  input  logic ras_n_i,
  input  logic cas_n_i,
  input  logic we_n_i,
  output cmd_e cmd_o
);
  always_comb begin
    unique case ({ras_n_i, cas_n_i, we_n_i})
      3'b011:  cmd_o = CMD_ACT;
      3'b010:  cmd_o = CMD_PRE;
      3'b101:  cmd_o = CMD_RD;
      3'b100:  cmd_o = CMD_WR;
      default: cmd_o = CMD_NOP;
    endcase
  end
endmodule

// File: rtl/sdram_rcd_tracker.sv
module sdram_rcd_tracker #(
  parameter int unsigned TRCD = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  input  logic pre_i,
  input  logic col_req_i,
  output logic ok_o,
  output logic err_o
);
  localparam int unsigned CW = $clog2(TRCD + 1);
  localparam logic [CW-1:0] GAP_MIN = CW'(TRCD);

  logic          open_q;
  logic [CW-1:0] gap_q;
  logic          err_q;

  // gap_q equals the number of edges since activate, saturating at TRCD
  assign ok_o  = open_q && (gap_q >= GAP_MIN);
  assign err_o = err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      gap_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q <= col_req_i && !ok_o;
      if (act_i) begin
        open_q <= 1'b1;
        gap_q  <= CW'(1);
      end else if (pre_i) begin
        open_q <= 1'b0;
        gap_q  <= '0;
      end else if (open_q && gap_q < GAP_MIN) begin
        gap_q <= gap_q + CW'(1);
      end
    end
  end
endmodule

// File: rtl/sdram_burst_engine.sv
module sdram_burst_engine
  import sdram_col_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       bl_i,
  input  logic             ilv_i,
  input  logic             wr_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             write_o
);
  logic             active_q;
  logic             full_q;
  logic             ilv_q;
  logic             wr_q;
  logic [COL_W-1:0] start_q;
  logic [COL_W-1:0] cnt_q;
  logic [COL_W-1:0] mask_q;
  logic [COL_W-1:0] mask_d;
  logic             full_d;
  logic [COL_W-1:0] pick;

  always_comb begin
    full_d = (bl_i == BL_PAGE);
    unique case (bl_i)
      BL_2:    mask_d = COL_W'(1);
      BL_4:    mask_d = COL_W'(3);
      BL_8:    mask_d = COL_W'(7);
      BL_PAGE: mask_d = '1;
      default: mask_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      full_q   <= 1'b0;
      ilv_q    <= 1'b0;
      wr_q     <= 1'b0;
      start_q  <= '0;
      cnt_q    <= '0;
      mask_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      full_q   <= full_d;
      ilv_q    <= ilv_i && !full_d;
      wr_q     <= wr_i;
      start_q  <= col_i;
      cnt_q    <= '0;
      mask_q   <= mask_d;
    end else if (active_q) begin
      if (stop_i || (!full_q && cnt_q == mask_q)) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + COL_W'(1);
      end
    end
  end

  // window base from start, offset from counter inside the mask
  assign pick    = ilv_q ? (start_q ^ cnt_q) : (start_q + cnt_q);
  assign col_o   = (start_q & ~mask_q) | (pick & mask_q);
  assign valid_o = active_q;
  assign write_o = wr_q;
endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
  import sdram_col_pkg::*;
#(
  parameter int unsigned COL_W = 8,
  parameter int unsigned TRCD  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ras_n_i,
  input  logic             cas_n_i,
  input  logic             we_n_i,
  input  logic [COL_W-1:0] col_i,
  input  logic [2:0]       burst_len_i,
  input  logic             interleave_i,
  input  logic             stop_i,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             write_o,
  output logic             trcd_err_o
);
  cmd_e cmd;
  logic col_req;
  logic col_ok;

  sdram_cmd_decode u_dec (
    .ras_n_i (ras_n_i),
    .cas_n_i (cas_n_i),
    .we_n_i  (we_n_i),
    .cmd_o   (cmd)
  );

  assign col_req = (cmd == CMD_RD) || (cmd == CMD_WR);

  sdram_rcd_tracker #(.TRCD(TRCD)) u_rcd (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .act_i     (cmd == CMD_ACT),
    .pre_i     (cmd == CMD_PRE),
    .col_req_i (col_req),
    .ok_o      (col_ok),
    .err_o     (trcd_err_o)
  );

  sdram_burst_engine #(.COL_W(COL_W)) u_eng (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (col_req && col_ok),
    .col_i   (col_i),
    .bl_i    (burst_len_i),
    .ilv_i   (interleave_i),
    .wr_i    (cmd == CMD_WR),
    .stop_i  (stop_i),
    .col_o   (col_o),
    .valid_o (valid_o),
    .write_o (write_o)
  );
endmodule

// File: rtl/sdram_col_burst_gen_chk.sv
module sdram_col_burst_gen_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ras_n_i,
  input logic             cas_n_i,
  input logic             we_n_i,
  input logic             stop_i,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             write_o,
  input logic             trcd_err_o
);
  logic col_cmd;
  assign col_cmd = ras_n_i && !cas_n_i;

  // R3
  p_err_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_cmd |=> !trcd_err_o);

  // R4
  p_accept_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_cmd |=> (trcd_err_o || valid_o));

  // R2
  p_dir_capture_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_cmd |=> (trcd_err_o || write_o == !$past(we_n_i)));

  // R2
  p_dir_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !col_cmd) |=> (!valid_o || write_o == $past(write_o)));

  // R11
  p_stop_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !col_cmd) |=> !valid_o);

  // R1
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |=> (!valid_o && !trcd_err_o));

  logic unused_col;
  assign unused_col = ^col_o;
endmodule

bind sdram_col_burst_gen sdram_col_burst_gen_chk #(.COL_W(COL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ras_n_i    (ras_n_i),
  .cas_n_i    (cas_n_i),
  .we_n_i     (we_n_i),
  .stop_i     (stop_i),
  .col_o      (col_o),
  .valid_o    (valid_o),
  .write_o    (write_o),
  .trcd_err_o (trcd_err_o)
);

// File: tb/sdram_col_burst_gen_tb_top.sv
module sdram_col_burst_gen_tb_top;
  localparam int COL_W = 8;
  localparam int TRCD  = 3;
  localparam int PAGE  = 1 << COL_W;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             ras_n_i = 1'b1;
  logic             cas_n_i = 1'b1;
  logic             we_n_i = 1'b1;
  logic [COL_W-1:0] col_i = '0;
  logic [2:0]       burst_len_i = 3'd0;
  logic             interleave_i = 1'b0;
  logic             stop_i = 1'b0;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             write_o;
  logic             trcd_err_o;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct {
    int    col;
    bit    wr;
    string req;
  } item_t;
  item_t sb_q[$];

  always #10 clk_i = ~clk_i;

  sdram_col_burst_gen #(.COL_W(COL_W), .TRCD(TRCD)) dut_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ras_n_i      (ras_n_i),
    .cas_n_i      (cas_n_i),
    .we_n_i       (we_n_i),
    .col_i        (col_i),
    .burst_len_i  (burst_len_i),
    .interleave_i (interleave_i),
    .stop_i       (stop_i),
    .col_o        (col_o),
    .valid_o      (valid_o),
    .write_o      (write_o),
    .trcd_err_o   (trcd_err_o)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // monitor: every valid beat must match the head of the scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R5", "unexpected valid beat col", int'(col_o), -1);
      end else begin
        item_t it;
        it = sb_q.pop_front();
        check(int'(col_o) == it.col, it.req, "burst column", int'(col_o), it.col);
        check(write_o == it.wr, "R2", "write flag", int'(write_o), int'(it.wr));
      end
    end
  end

  function automatic int len_of(input int bl);
    case (bl)
      1: return 2;
      2: return 4;
      3: return 8;
      7: return PAGE;
      default: return 1;
    endcase
  endfunction

  function automatic int exp_col(input int s, input int n, input int bl, input bit ilv);
    int l, base, off;
    l    = len_of(bl);
    base = s - (s % l);
    if (ilv && bl != 7) off = (s % l) ^ (n % l);
    else                off = (s + n) % l;
    return base + off;
  endfunction

  task automatic nop_pins();
    ras_n_i = 1'b1; cas_n_i = 1'b1; we_n_i = 1'b1; stop_i = 1'b0;
  endtask

  task automatic drive_col(input int c, input bit wr, input int bl, input bit ilv);
    ras_n_i = 1'b1; cas_n_i = 1'b0; we_n_i = !wr;
    col_i = COL_W'(c); burst_len_i = 3'(bl); interleave_i = ilv;
  endtask

  // caller stands at a negedge; returns at the negedge before edge E+keep
  task automatic finish_cmd(input int keep);
    @(negedge clk_i);
    check(trcd_err_o == 1'b0, "R3", "no error on legal command", int'(trcd_err_o), 0);
    nop_pins();
    repeat (keep - 1) @(negedge clk_i);
  endtask

  task automatic issue(input int c, input bit wr, input int bl, input bit ilv, input int keep, input string req);
    drive_col(c, wr, bl, ilv);
    for (int i = 0; i < keep; i++) sb_q.push_back('{exp_col(c, i, bl, ilv), wr, req});
    finish_cmd(keep);
  endtask

  task automatic activate();
    ras_n_i = 1'b0; cas_n_i = 1'b1; we_n_i = 1'b1;
    @(negedge clk_i);
    nop_pins();
  endtask

  task automatic precharge();
    ras_n_i = 1'b0; cas_n_i = 1'b1; we_n_i = 1'b0;
    @(negedge clk_i);
    nop_pins();
  endtask

  task automatic reject(input int c, input string req);
    drive_col(c, 1'b0, 3, 1'b0);
    @(negedge clk_i);
    check(trcd_err_o == 1'b1, req, "refused command flags error", int'(trcd_err_o), 1);
    nop_pins();
    @(negedge clk_i);
    check(trcd_err_o == 1'b0, req, "error lasts one cycle", int'(trcd_err_o), 0);
  endtask

  task automatic stop_now();
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
  endtask

  task automatic idle_check(input string req);
    repeat (4) @(negedge clk_i);
    check(sb_q.size() == 0, req, "all expected beats seen", sb_q.size(), 0);
    check(valid_o == 1'b0, req, "burst ended", int'(valid_o), 0);
  endtask

  task automatic run_tests();
    int ilv8[8] = '{2, 3, 0, 1, 6, 7, 4, 5};
    repeat (3) @(negedge clk_i);
    check(valid_o == 1'b0, "R1", "valid in reset", int'(valid_o), 0);
    check(trcd_err_o == 1'b0, "R1", "error in reset", int'(trcd_err_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(valid_o == 1'b0 && trcd_err_o == 1'b0, "R1", "outputs after reset",
          int'({valid_o, trcd_err_o}), 0);

    // R3: no row open
    reject(5, "R3");
    idle_check("R3");

    // R3: too early (2 edges), then legal at 4
    activate();
    @(negedge clk_i);
    reject(7, "R3");
    // R4 R6: sequential length 4 from 6 -> 6,7,4,5
    issue(6, 1'b0, 2, 1'b0, 4, "R6");
    idle_check("R5");

    // R7: interleaved length 8 from 2, literal order
    drive_col(2, 1'b0, 3, 1'b1);
    foreach (ilv8[i]) sb_q.push_back('{ilv8[i], 1'b0, "R7"});
    finish_cmd(8);
    idle_check("R7");

    // R5 R2: length 1 and 2 writes, reserved code
    issue(33, 1'b1, 0, 1'b0, 1, "R5");
    issue(33, 1'b1, 1, 1'b0, 2, "R5");
    issue(40, 1'b0, 5, 1'b1, 1, "R5");
    idle_check("R5");
    issue(13, 1'b0, 2, 1'b1, 4, "R7");
    idle_check("R7");

    // R8: full page wraps 250..255,0..3, then stopped
    issue(250, 1'b0, 7, 1'b0, 10, "R8");
    stop_now();
    idle_check("R8");

    // R9: full page with interleave requested runs sequential
    issue(254, 1'b1, 7, 1'b1, 5, "R9");
    stop_now();
    idle_check("R9");

    // R10: abort length 8 after 3 beats, new interleaved length 4 from 9
    issue(0, 1'b0, 3, 1'b0, 3, "R10");
    issue(9, 1'b1, 2, 1'b1, 4, "R10");
    idle_check("R10");

    // R11: stop ends a burst
    issue(16, 1'b0, 3, 1'b0, 2, "R11");
    stop_now();
    idle_check("R11");

    // R11: stop and column command on one edge, command wins
    issue(16, 1'b0, 3, 1'b0, 2, "R11");
    stop_i = 1'b1;
    issue(21, 1'b1, 1, 1'b0, 2, "R11");
    idle_check("R11");

    // R12 R3: precharge and refused command during a running burst
    drive_col(48, 1'b0, 3, 1'b0);
    for (int i = 0; i < 8; i++) sb_q.push_back('{exp_col(48, i, 3, 1'b0), 1'b0, "R3"});
    finish_cmd(2);
    precharge();
    reject(50, "R12");
    idle_check("R3");

    // R12: reopen with activate and wait TRCD
    activate();
    repeat (TRCD - 1) @(negedge clk_i);
    issue(100, 1'b1, 1, 1'b0, 2, "R12");
    idle_check("R12");
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++;
        n_fail++;
        $display("FAIL R1 watchdog: actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule